// File: doc/BRIEF.md
# Multimode Eight-Bit Addressable Latch

This block is a bank of eight single-bit storage cells. A three-bit address picks one cell, and a one-bit data input supplies its value. The eight cells drive eight parallel outputs. Writing one bit at a time through the single data line therefore builds up a parallel word that stays held, which turns a serial stream into stored parallel data.

Two active-low controls, a clear and an enable, pick one of four modes. In write mode the addressed cell is transparent to the data input and the other cells keep their values. In hold mode every cell keeps its value. In decode mode the bank works as a one-of-eight demultiplexer with active-high outputs. In clear mode every cell is forced low. Storage is level-sensitive and needs no clock. Several banks can be combined into a wider array by driving their enables from a higher-level address decode.

The address is only allowed to change while the enable is inactive (high). If it changes while the enable is low, the cell at an intermediate address may be written.

Top module: `addr_latch_bank`

## Requirements
- R1: The mode is set only by the pair {clr_n, en_n}: 2'b10 is write, 2'b11 is hold, 2'b00 is decode and 2'b01 is clear.
- R2: In write mode, output q[addr] transparently follows din for as long as the mode lasts.
- R3: In write mode, every output other than q[addr] keeps the value it had before.
- R4: In hold mode, all eight outputs keep their values whatever din and addr do.
- R5: In decode mode, q[addr] follows din and every other output is low, so at most one output is high.
- R6: Decode mode overwrites the unaddressed cells with zero, so after leaving it only the cell last addressed can hold a one.
- R7: In clear mode, all outputs are low whatever addr and din do, and this takes effect as soon as the controls change, without any clock.
- R8: Address value i in plain binary selects output bit q[i]; address 0 is q[0] and address 7 is q[7].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clr_n | input | 1 | Active-low clear control; together with en_n it selects the mode |
| en_n | input | 1 | Active-low enable; keep it high while addr changes |
| addr | input | 3 | Binary index of the addressed cell |
| din | input | 1 | Data level applied to the addressed cell |
| q | output | 8 | Parallel outputs, bit i belonging to address i |

## Verification
The table-driven sequence moves through all four modes. It sets bits at scattered addresses (3, 6, 0, 7) so that the bits written earlier show whether a later write disturbs its neighbours. Toggling din while a cell is addressed separates a transparent cell from an edge-captured one. Toggling din during hold mode shows whether the storage really ignores the data line. A decode sweep over every address, with din at both levels, checks that each address maps to its own output bit. The decode-then-hold step separates zeroed storage from outputs that are only masked. An asynchronous clear asserted between clock edges, with addr and din still moving, confirms that the clear overrides everything else.

// File: rtl/alb_pkg.sv
// Package: shared mode type and helpers for the addressable latch bank.
// Assumes the mode is formed as {clr_n, en_n}; the encoding below fixes that mapping.
package alb_pkg;

    typedef enum logic [1:0] {
        MODE_DECODE = 2'b00,
        MODE_CLEAR  = 2'b01,
        MODE_WRITE  = 2'b10,
        MODE_HOLD   = 2'b11
    } mode_e;

    // Combine the two active-low controls into a mode value.
    function automatic mode_e mode_of(input logic clr_n, input logic en_n);
        return mode_e'({clr_n, en_n});
    endfunction

endpackage

// File: rtl/alb_mode_ctrl.sv
// Module: alb_mode_ctrl
// Turns the two active-low controls into three per-bank strobes used by every cell.
// Assumes the controls are glitch-free at the level the surrounding logic needs.
module alb_mode_ctrl
    import alb_pkg::*;
(
    input  logic clr_n,
    input  logic en_n,
    output logic clear_all,
    output logic zero_unsel,
    output logic write_sel
);

    mode_e mode;

    // Decode the control pair into the mode and its strobes.
    always_comb begin
        mode       = mode_of(clr_n, en_n);
        clear_all  = (mode == MODE_CLEAR);
        zero_unsel = (mode == MODE_DECODE);
        write_sel  = (mode == MODE_WRITE) || (mode == MODE_DECODE);
    end

endmodule

// File: rtl/alb_addr_decode.sv
// Module: alb_addr_decode
// One-hot decoder: bit i of sel is high exactly when addr equals i.
// Assumes N_BITS is 2**ADDR_W.
module alb_addr_decode #(
    parameter int ADDR_W = 3,
    localparam int N_BITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_BITS-1:0] sel
);

    for (genvar i = 0; i < N_BITS; i++) begin : g_sel
        // Compare the address with this cell's index.
        always_comb sel[i] = (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/alb_bit_cell.sv
// Module: alb_bit_cell
// One level-sensitive storage cell. A clear or an unselected decode zeroes it;
// a selected write or decode makes it transparent to din; otherwise it holds.
// Assumes the strobes come from alb_mode_ctrl and sel from alb_addr_decode.
module alb_bit_cell (
    input  logic clear_all,
    input  logic zero_unsel,
    input  logic write_sel,
    input  logic sel,
    input  logic din,
    output logic q
);

    // Level-sensitive storage with zeroing taking priority over writing.
    always_latch begin
        if (clear_all || (zero_unsel && !sel))
            q = 1'b0;
        else if (write_sel && sel)
            q = din;
    end

endmodule

// File: rtl/addr_latch_bank.sv
// Module: addr_latch_bank (top)
// A bank of 2**ADDR_W addressable latches with four modes picked by clr_n and en_n:
// write, hold, decode and clear. There is no clock; clear acts asynchronously.
// Assumes addr changes only while en_n is high.
module addr_latch_bank #(
    parameter int ADDR_W = 3,
    localparam int N_BITS = 1 << ADDR_W
) (
    input  logic              clr_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [N_BITS-1:0] q
);

    logic              clear_all;
    logic              zero_unsel;
    logic              write_sel;
    logic [N_BITS-1:0] sel;

    alb_mode_ctrl i_mode (
        .clr_n      (clr_n),
        .en_n       (en_n),
        .clear_all  (clear_all),
        .zero_unsel (zero_unsel),
        .write_sel  (write_sel)
    );

    alb_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < N_BITS; i++) begin : g_cell
        alb_bit_cell i_cell (
            .clear_all  (clear_all),
            .zero_unsel (zero_unsel),
            .write_sel  (write_sel),
            .sel        (sel[i]),
            .din        (din),
            .q          (q[i])
        );
    end

endmodule

// File: rtl/alb_checker.sv
// Module: alb_checker
// Checks the bank's outputs against its controls in each mode. It has no clock, so it
// uses immediate assertions that are re-evaluated whenever an input or output changes.
module alb_checker #(
    parameter int ADDR_W = 3,
    localparam int N_BITS = 1 << ADDR_W
) (
    input logic              clr_n,
    input logic              en_n,
    input logic [ADDR_W-1:0] addr,
    input logic              din,
    input logic [N_BITS-1:0] q
);

    // Mode-dependent output properties.
    always_comb begin
        if (!clr_n && en_n) begin
            p_clear_zero_r7: assert (q == '0)
                else $error("clear mode output not zero");
        end
        if (!clr_n && !en_n) begin
            p_decode_onehot_r5: assert ($onehot0(q))
                else $error("decode mode drives more than one output");
            p_decode_follow_r5: assert (q[addr] == din)
                else $error("decode mode addressed output differs from din");
        end
        if (clr_n && !en_n) begin
            p_write_follow_r2: assert (q[addr] == din)
                else $error("write mode addressed output differs from din");
        end
    end

endmodule

bind addr_latch_bank alb_checker #(.ADDR_W(ADDR_W)) i_alb_checker (
    .clr_n (clr_n),
    .en_n  (en_n),
    .addr  (addr),
    .din   (din),
    .q     (q)
);

// File: tb/test_addr_latch_bank.sv
// Bench for addr_latch_bank: a vector table walked by one loop, then directed tests.
module test_addr_latch_bank;

    logic       clk = 1'b0;
    logic       clr_n;
    logic       en_n;
    logic [2:0] addr;
    logic       din;
    logic [7:0] q;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    addr_latch_bank i_addr_latch_bank (
        .clr_n (clr_n),
        .en_n  (en_n),
        .addr  (addr),
        .din   (din),
        .q     (q)
    );

    typedef struct packed {
        logic       clr_n;
        logic       en_n;
        logic [2:0] addr;
        logic       din;
        logic [7:0] exp;
    } vec_t;

    // Modes: {clr_n,en_n} 10 write, 11 hold, 00 decode, 01 clear (R1).
    localparam vec_t VEC [20] = '{
        '{1'b0, 1'b1, 3'd0, 1'b0, 8'h00},  // clear
        '{1'b1, 1'b1, 3'd3, 1'b1, 8'h00},  // hold, move address
        '{1'b1, 1'b0, 3'd3, 1'b1, 8'h08},  // write bit 3
        '{1'b1, 1'b0, 3'd3, 1'b0, 8'h00},  // transparent follow
        '{1'b1, 1'b0, 3'd3, 1'b1, 8'h08},
        '{1'b1, 1'b1, 3'd6, 1'b1, 8'h08},  // hold
        '{1'b1, 1'b0, 3'd6, 1'b1, 8'h48},  // write bit 6, bit 3 kept
        '{1'b1, 1'b1, 3'd0, 1'b1, 8'h48},
        '{1'b1, 1'b0, 3'd0, 1'b1, 8'h49},
        '{1'b1, 1'b1, 3'd7, 1'b0, 8'h49},  // hold ignores din
        '{1'b1, 1'b1, 3'd7, 1'b1, 8'h49},
        '{1'b1, 1'b0, 3'd7, 1'b1, 8'hC9},
        '{1'b1, 1'b1, 3'd2, 1'b1, 8'hC9},
        '{1'b0, 1'b0, 3'd2, 1'b1, 8'h04},  // decode
        '{1'b0, 1'b0, 3'd2, 1'b0, 8'h00},
        '{1'b0, 1'b0, 3'd2, 1'b1, 8'h04},
        '{1'b1, 1'b1, 3'd2, 1'b1, 8'h04},  // leave decode: storage zeroed
        '{1'b0, 1'b1, 3'd5, 1'b1, 8'h00},  // clear
        '{1'b1, 1'b1, 3'd5, 1'b1, 8'h00},
        '{1'b1, 1'b0, 3'd5, 1'b1, 8'h20}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic c, input logic e, input logic [2:0] a, input logic d);
        @(negedge clk);
        clr_n = c; en_n = e; addr = a; din = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        clr_n = 1'b0; en_n = 1'b1; addr = 3'd0; din = 1'b0;
        @(posedge clk); #2;
        chk("R7 reset clear state", q, 8'h00);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 20; i++) begin
            apply(VEC[i].clr_n, VEC[i].en_n, VEC[i].addr, VEC[i].din);
            chk($sformatf("R1 table row %0d", i), q, VEC[i].exp);
        end

        // R8 and R3: fill all bits one by one in write mode
        apply(1'b0, 1'b1, 3'd0, 1'b0);
        for (int a = 0; a < 8; a++) begin
            apply(1'b1, 1'b1, 3'(a), 1'b1);
            apply(1'b1, 1'b0, 3'(a), 1'b1);
            chk($sformatf("R8 write addr %0d", a), q, 8'((1 << (a + 1)) - 1));
        end

        // R4: hold ignores din toggles
        apply(1'b1, 1'b1, 3'd4, 1'b0);
        apply(1'b1, 1'b1, 3'd4, 1'b1);
        chk("R4 hold keeps word", q, 8'hFF);

        // R5 and R8: decode sweep
        for (int a = 0; a < 8; a++) begin
            apply(1'b1, 1'b1, 3'(a), 1'b1);
            apply(1'b0, 1'b0, 3'(a), 1'b1);
            chk($sformatf("R5 decode addr %0d din 1", a), q, 8'(1 << a));
            apply(1'b0, 1'b0, 3'(a), 1'b0);
            chk($sformatf("R5 decode addr %0d din 0", a), q, 8'h00);
        end

        // R6: decode then hold leaves only addressed bit
        apply(1'b1, 1'b1, 3'd1, 1'b1);
        apply(1'b1, 1'b0, 3'd1, 1'b1);
        apply(1'b1, 1'b1, 3'd6, 1'b1);
        apply(1'b0, 1'b0, 3'd6, 1'b1);
        apply(1'b1, 1'b1, 3'd6, 1'b1);
        chk("R6 decode zeroed storage", q, 8'h40);

        // R7: asynchronous clear between edges while addr and din move
        apply(1'b1, 1'b0, 3'd6, 1'b1);
        @(negedge clk);
        #3 clr_n = 1'b0; en_n = 1'b1; addr = 3'd2; din = 1'b1;
        #1 chk("R7 clear acts without clock", q, 8'h00);
        #2 addr = 3'd5; din = 1'b0;
        #1 chk("R7 clear ignores addr and din", q, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule